// File: doc/BRIEF.md
# Dual-Style 8-Bit Host Bus Port

This block connects an 8-bit microprocessor bus to a display controller that runs on its own clock. It accepts two bus styles. In the enable style, one enable pulse frames an access and a separate level gives its direction. In the strobe style, two separate active-low strobes are used, one for read and one for write. The bus has no dedicated mode pin. The level held on the reset pin chooses the style, and the falling edge of that pin starts a timed internal reset.

All bus inputs pass through a two-stage register pipeline into the internal clock domain. A state machine tracks each access with the states `ST_ARM`, `ST_IDLE`, `ST_READ` and `ST_WRITE`. It moves through these transitions:

- `arm_done`: `ST_ARM` to `ST_IDLE`, once no strobe is active.
- `start_rd`: `ST_IDLE` to `ST_READ`.
- `start_wr`: `ST_IDLE` to `ST_WRITE`.
- `finish`: `ST_READ` or `ST_WRITE` back to `ST_IDLE`, when the strobe ends.
- `mode_abort`: any state to `ST_ARM`, when the bus style changes.

Each completed access gives the downstream controller one single-cycle event. The event carries the direction, the address-select level and, for writes, the byte. Reads drive the bus with memory data or with a packed status byte.

Top module: `hostbus_port`

## Requirements
- R1: With the reset pin high, the enable style is used. An access is framed by `strb_a` high, and `strb_b` high marks a read while `strb_b` low marks a write.
- R2: With the reset pin low, the strobe style is used. `strb_a` low is a read strobe, `strb_b` low is a write strobe, and both high is idle.
- R3: Every access produces exactly one `evt_valid` pulse, one clock wide, after its strobe ends, however long the strobe is held.
- R4: A write event reports `evt_read`=0, `evt_data` equal to `a0` (1 = display data, 0 = instruction) and `evt_byte` equal to the byte on `db_in` during the strobe.
- R5: During a read strobe, `db_oe` is 1. It returns to 0 after the strobe ends. With `a0`=1 the bus carries `rd_data`. The read event reports `evt_read`=1 and `evt_byte`=0.
- R6: A read with `a0`=0 returns a status byte laid out as follows. Bit 7 is busy, which is `stat_busy` OR reset in progress. Bit 6 is `stat_dir`, bit 5 is `stat_off`, bit 4 is reset in progress, and bits 3..0 are 0.
- R7: A falling edge on the reset pin starts a reset window of `RST_CYCLES` clocks. A window also starts after `sys_rst_n`. During the window, status reads show busy=1 and reset=1, and accesses that complete produce no event.
- R8: A rising edge on the reset pin, or a steady level on it, starts no reset window. Status bit 4 reads 0 and writes produce events at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| sys_rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | Reset pin: level picks the bus style, falling edge starts the reset window |
| a0 | input | 1 | Address select: 1 = display data, 0 = instruction/status |
| strb_a | input | 1 | Enable (enable style) or active-low read strobe (strobe style) |
| strb_b | input | 1 | Direction, 1 = read (enable style), or active-low write strobe (strobe style) |
| db_in | input | 8 | Bus byte from the host |
| db_out | output | 8 | Byte returned to the host |
| db_oe | output | 1 | Output enable for the bus driver |
| rd_data | input | 8 | Display memory byte at the current address |
| stat_busy | input | 1 | Controller internal operation in progress |
| stat_dir | input | 1 | Column direction flag for the status byte |
| stat_off | input | 1 | Display off flag for the status byte |
| evt_valid | output | 1 | Single-cycle access event |
| evt_read | output | 1 | Event is a read |
| evt_data | output | 1 | Event address select (a0) |
| evt_byte | output | 8 | Written byte, 0 for reads |

## Verification
Data and instruction writes are issued in both bus styles, using distinct bytes. This shows that `a0` and the byte are carried through, and that the two strobe encodings are decoded differently. A strobe held forty cycles tells a single edge event apart from a level-driven repeat. Status reads with contrasting flag patterns confirm each bit position. Reset-pin falls and rises separate edge-started reset windows from level-only style changes, and show that events are suppressed inside the window.

// File: rtl/hif_pkg.sv
package hif_pkg;
    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } hif_state_t;

    localparam int BYTE_W   = 8;
    localparam int SB_BUSY  = 7;
    localparam int SB_DIR   = 6;
    localparam int SB_OFF   = 5;
    localparam int SB_RST   = 4;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int          W         = 1,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         sys_rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    // two-stage capture, one chain per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk or negedge sys_rst_n) begin
            if (!sys_rst_n) begin
                st1 <= RESET_VAL[i];
                st2 <= RESET_VAL[i];
            end else begin
                st1 <= d_in[i];
                st2 <= st1;
            end
        end
        assign d_out[i] = st2;
    end
endmodule

// File: rtl/hif_reset_ctl.sv
module hif_reset_ctl #(
    parameter int RST_CYCLES = 50
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic rst_pin,
    output logic mode68,
    output logic mode_chg,
    output logic rst_busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);

    logic          pin_s;
    logic          pin_prev;
    logic          pin_fall;
    logic [CW-1:0] cnt;

    hif_sync #(.W(1), .RESET_VAL(1'b1)) u_pin_sync (
        .clk(clk), .sys_rst_n(sys_rst_n), .d_in(rst_pin), .d_out(pin_s)
    );

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) pin_prev <= 1'b1;
        else            pin_prev <= pin_s;
    end

    assign pin_fall = pin_prev & ~pin_s;
    assign mode_chg = pin_prev ^ pin_s;
    assign mode68   = pin_s;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)      cnt <= CNT_LOAD;
        else if (pin_fall)   cnt <= CNT_LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign rst_busy = (cnt != '0);
endmodule

// File: rtl/hif_fsm.sv
module hif_fsm
    import hif_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              mode68,
    input  logic              mode_chg,
    input  logic              rst_busy,
    input  logic              stb_a,
    input  logic              stb_b,
    input  logic              a0_s,
    input  logic [BYTE_W-1:0] data_s,
    output logic              lat_a0,
    output logic              db_oe,
    output logic              evt_valid,
    output logic              evt_read,
    output logic              evt_data,
    output logic [BYTE_W-1:0] evt_byte
);
    hif_state_t        state, nxt;
    logic              act, is_rd, fin;
    logic [BYTE_W-1:0] lat_byte;

    // decode the access from the synchronised strobes
    always_comb begin
        if (mode68) begin
            act   = stb_a;
            is_rd = stb_b;
        end else begin
            act   = ~stb_a | ~stb_b;
            is_rd = ~stb_a;
        end
    end

    always_comb begin
        nxt = state;
        fin = 1'b0;
        if (mode_chg) begin
            nxt = ST_ARM;                       // mode_abort
        end else begin
            unique case (state)
                ST_ARM:   if (!act) nxt = ST_IDLE;  // arm_done
                ST_IDLE:  if (act) nxt = is_rd ? ST_READ : ST_WRITE;
                ST_READ,
                ST_WRITE: if (!act) begin
                    nxt = ST_IDLE;                  // finish
                    fin = 1'b1;
                end
                default:  nxt = ST_ARM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) state <= ST_ARM;
        else            state <= nxt;
    end

    // outputs and captured fields
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            lat_a0    <= 1'b0;
            lat_byte  <= '0;
            evt_valid <= 1'b0;
            evt_read  <= 1'b0;
            evt_data  <= 1'b0;
            evt_byte  <= '0;
        end else begin
            if (state == ST_IDLE && act) lat_a0 <= a0_s;
            if ((state == ST_IDLE || state == ST_WRITE) && act) lat_byte <= data_s;
            evt_valid <= fin & ~rst_busy;
            if (fin) begin
                evt_read <= (state == ST_READ);
                evt_data <= lat_a0;
                evt_byte <= (state == ST_WRITE) ? lat_byte : '0;
            end
        end
    end

    assign db_oe = (state == ST_READ);
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hif_pkg::*;
#(
    parameter int RST_CYCLES = 50
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              rst_pin,
    input  logic              a0,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic [BYTE_W-1:0] db_in,
    output logic [BYTE_W-1:0] db_out,
    output logic              db_oe,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              stat_busy,
    input  logic              stat_dir,
    input  logic              stat_off,
    output logic              evt_valid,
    output logic              evt_read,
    output logic              evt_data,
    output logic [BYTE_W-1:0] evt_byte
);
    localparam int SW = BYTE_W + 3;

    logic [SW-1:0]     bus_s;
    logic              mode68, mode_chg, rst_busy, lat_a0;
    logic [BYTE_W-1:0] status_byte;

    hif_sync #(.W(SW), .RESET_VAL('0)) u_bus_sync (
        .clk(clk), .sys_rst_n(sys_rst_n),
        .d_in({a0, db_in, strb_b, strb_a}), .d_out(bus_s)
    );

    hif_reset_ctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin(rst_pin),
        .mode68(mode68), .mode_chg(mode_chg), .rst_busy(rst_busy)
    );

    hif_fsm u_fsm (
        .clk(clk), .sys_rst_n(sys_rst_n),
        .mode68(mode68), .mode_chg(mode_chg), .rst_busy(rst_busy),
        .stb_a(bus_s[0]), .stb_b(bus_s[1]),
        .a0_s(bus_s[SW-1]), .data_s(bus_s[BYTE_W+1:2]),
        .lat_a0(lat_a0), .db_oe(db_oe),
        .evt_valid(evt_valid), .evt_read(evt_read),
        .evt_data(evt_data), .evt_byte(evt_byte)
    );

    always_comb begin
        status_byte          = '0;
        status_byte[SB_BUSY] = stat_busy | rst_busy;
        status_byte[SB_DIR]  = stat_dir;
        status_byte[SB_OFF]  = stat_off;
        status_byte[SB_RST]  = rst_busy;
    end

    assign db_out = lat_a0 ? rd_data : status_byte;
endmodule

// File: rtl/hif_checker.sv
module hif_checker (
    input logic       clk,
    input logic       sys_rst_n,
    input logic       evt_valid,
    input logic       evt_read,
    input logic       db_oe,
    input logic [7:0] db_out,
    input logic       rst_busy,
    input logic       lat_a0
);
    assert_evt_single_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        evt_valid |=> !evt_valid);

    assert_no_evt_in_reset_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        evt_valid |-> !$past(rst_busy));

    assert_read_evt_after_oe_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (evt_valid && evt_read) |-> $past(db_oe));

    assert_write_evt_no_oe_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (evt_valid && !evt_read) |-> !$past(db_oe));

    assert_status_low_zero_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (db_oe && !lat_a0) |-> (db_out[3:0] == 4'h0));

    assert_status_reset_flags_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (db_oe && !lat_a0 && rst_busy) |-> (db_out[7] && db_out[4]));
endmodule

bind hostbus_port hif_checker u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .evt_valid(evt_valid), .evt_read(evt_read),
    .db_oe(db_oe), .db_out(db_out), .rst_busy(rst_busy), .lat_a0(lat_a0)
);

// File: tb/tb_hostbus_port.sv
module tb_hostbus_port;
    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       rst_pin = 1'b1;
    logic       a0 = 1'b0;
    logic       strb_a = 1'b0;
    logic       strb_b = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic [7:0] rd_data = 8'h00;
    logic       stat_busy = 1'b0, stat_dir = 1'b0, stat_off = 1'b0;
    logic [7:0] db_out, evt_byte;
    logic       db_oe, evt_valid, evt_read, evt_data;

    int checks = 0, failures = 0, evt_cnt = 0;
    logic       last_read, last_data;
    logic [7:0] last_byte;

    always #10 clk = ~clk;

    hostbus_port dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin(rst_pin), .a0(a0),
        .strb_a(strb_a), .strb_b(strb_b), .db_in(db_in), .db_out(db_out),
        .db_oe(db_oe), .rd_data(rd_data), .stat_busy(stat_busy),
        .stat_dir(stat_dir), .stat_off(stat_off), .evt_valid(evt_valid),
        .evt_read(evt_read), .evt_data(evt_data), .evt_byte(evt_byte)
    );

    always @(posedge clk) begin
        if (evt_valid) begin
            evt_cnt   <= evt_cnt + 1;
            last_read <= evt_read;
            last_data <= evt_data;
            last_byte <= evt_byte;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // enable-style access; returns bus state seen near strobe end
    task automatic acc68(input bit rd, input bit av, input logic [7:0] d, input int hold,
                         output logic [7:0] seen, output logic seen_oe, output logic oe_after);
        @(negedge clk); a0 = av; strb_b = rd; db_in = d;
        @(negedge clk); strb_a = 1'b1;
        repeat (hold) @(negedge clk);
        seen = db_out; seen_oe = db_oe;
        strb_a = 1'b0;
        repeat (6) @(negedge clk);
        oe_after = db_oe;
    endtask

    // strobe-style access
    task automatic acc80(input bit rd, input bit av, input logic [7:0] d, input int hold,
                         output logic [7:0] seen, output logic seen_oe, output logic oe_after);
        @(negedge clk); a0 = av; db_in = d;
        @(negedge clk); if (rd) strb_a = 1'b0; else strb_b = 1'b0;
        repeat (hold) @(negedge clk);
        seen = db_out; seen_oe = db_oe;
        strb_a = 1'b1; strb_b = 1'b1;
        repeat (6) @(negedge clk);
        oe_after = db_oe;
    endtask

    task automatic t_reset_state();
        logic [7:0] s; logic o, oa;
        chk("R7", "oe after reset", db_oe, 0);
        acc68(1'b1, 1'b0, 8'h00, 6, s, o, oa);
        chk("R7", "status in window", s, 8'h90);
        chk("R7", "no event in window", evt_cnt, 0);
        repeat (60) @(negedge clk);
    endtask

    task automatic t_write68();
        logic [7:0] s; logic o, oa; int base;
        base = evt_cnt;
        acc68(1'b0, 1'b1, 8'hA5, 6, s, o, oa);
        chk("R1", "write event count", evt_cnt, base + 1);
        chk("R4", "data write fields", {last_read, last_data, last_byte}, {1'b0, 1'b1, 8'hA5});
        chk("R4", "no oe on write", o, 0);
        acc68(1'b0, 1'b0, 8'h3C, 6, s, o, oa);
        chk("R4", "instr write fields", {last_read, last_data, last_byte}, {1'b0, 1'b0, 8'h3C});
    endtask

    task automatic t_read68();
        logic [7:0] s; logic o, oa; int base;
        base = evt_cnt; rd_data = 8'h5A;
        acc68(1'b1, 1'b1, 8'h00, 6, s, o, oa);
        chk("R5", "oe during read", o, 1);
        chk("R5", "read data", s, 8'h5A);
        chk("R5", "oe released", oa, 0);
        chk("R5", "read event", {evt_cnt - base, 32'(last_read), 32'(last_data), 32'(last_byte)},
            {1, 32'd1, 32'd1, 32'd0});
    endtask

    task automatic t_status();
        logic [7:0] s; logic o, oa;
        stat_busy = 1'b1; stat_dir = 1'b0; stat_off = 1'b1;
        acc68(1'b1, 1'b0, 8'h00, 6, s, o, oa);
        chk("R6", "status busy/off", s, 8'hA0);
        stat_busy = 1'b0; stat_dir = 1'b1; stat_off = 1'b0;
        acc68(1'b1, 1'b0, 8'h00, 6, s, o, oa);
        chk("R6", "status dir", s, 8'h40);
        stat_dir = 1'b0;
    endtask

    task automatic t_long();
        logic [7:0] s; logic o, oa; int base;
        base = evt_cnt;
        acc68(1'b0, 1'b1, 8'h77, 40, s, o, oa);
        chk("R3", "one event for long strobe", evt_cnt, base + 1);
    endtask

    task automatic t_to80();
        logic [7:0] s; logic o, oa; int base;
        @(negedge clk); strb_b = 1'b1;
        @(negedge clk); rst_pin = 1'b0; strb_a = 1'b1;
        repeat (8) @(negedge clk);
        base = evt_cnt;
        acc80(1'b1, 1'b0, 8'h00, 6, s, o, oa);
        chk("R7", "status after pin fall", s, 8'h90);
        acc80(1'b0, 1'b1, 8'h11, 6, s, o, oa);
        chk("R7", "write in window dropped", evt_cnt, base);
        repeat (60) @(negedge clk);
        acc80(1'b0, 1'b1, 8'hC3, 6, s, o, oa);
        chk("R2", "strobe-style write", {evt_cnt - base, 32'(last_read), 32'(last_byte)},
            {1, 32'd0, 32'hC3});
        rd_data = 8'h81;
        acc80(1'b1, 1'b1, 8'h00, 6, s, o, oa);
        chk("R2", "strobe-style read", {32'(o), 32'(s), 32'(oa)}, {32'd1, 32'h81, 32'd0});
        chk("R2", "read event", {evt_cnt - base, 32'(last_read)}, {2, 32'd1});
    endtask

    task automatic t_to68();
        logic [7:0] s; logic o, oa; int base;
        @(negedge clk); rst_pin = 1'b1; strb_a = 1'b0;
        repeat (8) @(negedge clk);
        acc68(1'b1, 1'b0, 8'h00, 6, s, o, oa);
        chk("R8", "no reset flag after rise", s, 8'h00);
        base = evt_cnt;
        acc68(1'b0, 1'b1, 8'h5E, 6, s, o, oa);
        chk("R8", "write accepted at once", {evt_cnt - base, 32'(last_byte)}, {1, 32'h5E});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sys_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_write68();
        t_read68();
        t_status();
        t_long();
        t_to80();
        t_to68();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule